// File: doc/BRIEF.md
# Vector Lane Permute Unit

This block is a registered 128-bit lane rearrangement datapath. Each cycle it may accept two source vectors, an 8-bit immediate and a 4-bit operation code. One clock edge later it presents the permuted 128-bit result together with a valid flag. A new operation can be issued on every cycle, so back-to-back streams run at full rate.

The operations fall into four groups:
- a two-lane 64-bit shuffle driven by the immediate;
- a byte window taken from the 32-byte concatenation of the two sources;
- lane permutes whose selectors come from the second vector, at 64-bit and 32-bit granularity;
- six group shuffles, which copy the first source and overwrite one fixed four-element group with elements picked from the same group of the second source.

An unknown operation code returns the first source unchanged and raises a flag.

Top module: `vperm_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the edge clears `out_valid`, `out_illegal` and `out_data` to zero.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock, and a new operation is accepted on every cycle with no bubbles.
- R3: op 0 (immediate 64-bit shuffle). For result lane i (0 or 1), s = imm[2i+1:2i]. When s is 0 or 1 the lane is `src_a` lane s; when s is 2 or 3 it is `src_b` lane s-2.
- R4: op 1 (byte window). Let p = imm[4:0] + k. Result byte k is `src_b` byte p when p < 16, `src_a` byte p-16 when 16 <= p < 32, and zero when p >= 32. imm[7:5] are ignored.
- R5: op 2 (vector 64-bit permute). Result 64-bit lane i is `src_a` lane selected by bit 0 of `src_b` lane i.
- R6: op 3 (vector 32-bit permute). Result 32-bit lane i is `src_a` lane selected by bits [1:0] of `src_b` lane i.
- R7: ops 4 and 5 (16-bit group shuffles, group bases 0 and 4). Result element base+j is `src_b` element base+imm[2j+1:2j], for j = 0..3.
- R8: ops 6, 7, 8 and 9 (8-bit group shuffles, group bases 0, 4, 8 and 12). Result byte base+j is `src_b` byte base+imm[2j+1:2j], for j = 0..3.
- R9: For ops 4 to 9, every element outside the selected group equals the same element of `src_a`.
- R10: ops 10 to 15 return `src_a` unchanged and set `out_illegal` in the same cycle as `out_valid`. Ops 0 to 9 leave `out_illegal` low, and `out_illegal` is never high without `out_valid`.
- R11: When `in_valid` is low at a clock edge, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code |
| imm | input | 8 | Immediate selector field |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector, or per-lane control |
| out_valid | output | 1 | Result valid |
| out_illegal | output | 1 | Operation code was not recognised |
| out_data | output | 128 | Permuted result |

## Verification
The block keeps only one register stage of state, so any internal fault shows at the ports on the cycle right after the operation that triggered it. The symptoms are:
- a wrong selector decode shows as a misplaced lane or byte;
- a wrong group base or element width corrupts lanes that should have come from `src_a`;
- a faulty valid pipeline shows as a dropped or extra `out_valid` pulse.

Back-to-back random operations are compared cycle by cycle. Directed cases cover the window edges at offsets 0, 15, 16 and 31 and the ignored high immediate bits, all illegal codes, and holding the output while idle.

// File: rtl/vperm_pkg.sv
package vperm_pkg;

    localparam int VEC_W   = 128;
    localparam int OP_W    = 4;
    localparam int IMM_W   = 8;
    localparam int BYTE_W  = 8;
    localparam int N_BYTES = VEC_W / BYTE_W;
    localparam int WIN_W   = $clog2(2 * N_BYTES);
    localparam int N_GRP   = 6;
    localparam int GRP_LEN = 4;

    typedef enum logic [OP_W-1:0] {
        OP_SHUF64  = 4'd0,
        OP_WINDOW  = 4'd1,
        OP_VPERM64 = 4'd2,
        OP_VPERM32 = 4'd3,
        OP_GRP_H0  = 4'd4,
        OP_GRP_H4  = 4'd5,
        OP_GRP_B0  = 4'd6,
        OP_GRP_B4  = 4'd7,
        OP_GRP_B8  = 4'd8,
        OP_GRP_B12 = 4'd9
    } perm_op_e;

    localparam logic [OP_W-1:0] OP_LAST_LEGAL = 4'd9;

    typedef struct packed {
        logic             valid;
        logic             illegal;
        logic [VEC_W-1:0] data;
    } perm_out_t;

    // Two 64-bit lanes picked from the four-lane concatenation {b, a}.
    function automatic logic [VEC_W-1:0] shuf64(
        input logic [VEC_W-1:0] a,
        input logic [VEC_W-1:0] b,
        input logic [3:0]       sel
    );
        logic [2*VEC_W-1:0] cat;
        logic [VEC_W-1:0]   r;
        cat = {b, a};
        for (int i = 0; i < 2; i++) begin
            r[i*64 +: 64] = cat[int'(sel[2*i +: 2])*64 +: 64];
        end
        return r;
    endfunction

    function automatic logic is_legal(input logic [OP_W-1:0] code);
        return code <= OP_LAST_LEGAL;
    endfunction

endpackage

// File: rtl/vperm_window.sv
module vperm_window
    import vperm_pkg::*;
(
    input  logic [VEC_W-1:0] lo_vec,
    input  logic [VEC_W-1:0] hi_vec,
    input  logic [WIN_W-1:0] offset,
    output logic [VEC_W-1:0] result
);
    logic [2*VEC_W-1:0] cat;
    assign cat = {hi_vec, lo_vec};

    for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
        logic [WIN_W:0] pos;
        assign pos = {1'b0, offset} + (WIN_W+1)'(k);
        assign result[k*BYTE_W +: BYTE_W] =
            pos[WIN_W] ? '0 : cat[int'(pos[WIN_W-1:0])*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/vperm_lane_sel.sv
module vperm_lane_sel
    import vperm_pkg::*;
#(
    parameter int ELEM_W = 64
)(
    input  logic [VEC_W-1:0] data_vec,
    input  logic [VEC_W-1:0] ctl_vec,
    output logic [VEC_W-1:0] result
);
    localparam int N_ELEM = VEC_W / ELEM_W;
    localparam int SEL_W  = $clog2(N_ELEM);

    logic [VEC_W-1:0] unused_ctl;
    assign unused_ctl = ctl_vec;

    for (genvar i = 0; i < N_ELEM; i++) begin : g_lane
        logic [SEL_W-1:0] sel;
        assign sel = ctl_vec[i*ELEM_W +: SEL_W];
        assign result[i*ELEM_W +: ELEM_W] = data_vec[int'(sel)*ELEM_W +: ELEM_W];
    end
endmodule

// File: rtl/vperm_group.sv
module vperm_group
    import vperm_pkg::*;
#(
    parameter int ELEM_W = 8,
    parameter int BASE   = 0
)(
    input  logic [VEC_W-1:0] keep_vec,
    input  logic [VEC_W-1:0] pick_vec,
    input  logic [IMM_W-1:0] sel,
    output logic [VEC_W-1:0] result
);
    always_comb begin
        result = keep_vec;
        for (int j = 0; j < GRP_LEN; j++) begin
            result[(BASE+j)*ELEM_W +: ELEM_W] =
                pick_vec[(BASE + int'(sel[2*j +: 2]))*ELEM_W +: ELEM_W];
        end
    end
endmodule

// File: rtl/vperm_unit.sv
module vperm_unit
    import vperm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  op,
    input  logic [IMM_W-1:0] imm,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    output logic             out_valid,
    output logic             out_illegal,
    output logic [VEC_W-1:0] out_data
);
    logic [VEC_W-1:0] win_res;
    logic [VEC_W-1:0] p64_res;
    logic [VEC_W-1:0] p32_res;
    logic [VEC_W-1:0] grp_res [N_GRP];
    logic [VEC_W-1:0] nxt_data;
    logic             nxt_illegal;
    perm_out_t        out_q;

    vperm_window i_window (
        .lo_vec (src_b),
        .hi_vec (src_a),
        .offset (imm[WIN_W-1:0]),
        .result (win_res)
    );

    vperm_lane_sel #(.ELEM_W(64)) i_perm64 (
        .data_vec (src_a),
        .ctl_vec  (src_b),
        .result   (p64_res)
    );

    vperm_lane_sel #(.ELEM_W(32)) i_perm32 (
        .data_vec (src_a),
        .ctl_vec  (src_b),
        .result   (p32_res)
    );

    // Groups 0..1 are 16-bit elements, groups 2..5 are 8-bit elements.
    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        localparam int GW = (g < 2) ? 16 : 8;
        localparam int GB = (g < 2) ? g * GRP_LEN : (g - 2) * GRP_LEN;
        vperm_group #(.ELEM_W(GW), .BASE(GB)) i_grp (
            .keep_vec (src_a),
            .pick_vec (src_b),
            .sel      (imm),
            .result   (grp_res[g])
        );
    end

    always_comb begin
        nxt_illegal = !is_legal(op);
        case (op)
            OP_SHUF64:  nxt_data = shuf64(src_a, src_b, imm[3:0]);
            OP_WINDOW:  nxt_data = win_res;
            OP_VPERM64: nxt_data = p64_res;
            OP_VPERM32: nxt_data = p32_res;
            OP_GRP_H0:  nxt_data = grp_res[0];
            OP_GRP_H4:  nxt_data = grp_res[1];
            OP_GRP_B0:  nxt_data = grp_res[2];
            OP_GRP_B4:  nxt_data = grp_res[3];
            OP_GRP_B8:  nxt_data = grp_res[4];
            OP_GRP_B12: nxt_data = grp_res[5];
            default:    nxt_data = src_a;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid   <= in_valid;
            out_q.illegal <= in_valid && nxt_illegal;
            if (in_valid) begin
                out_q.data <= nxt_data;
            end
        end
    end

    assign out_valid   = out_q.valid;
    assign out_illegal = out_q.illegal;
    assign out_data    = out_q.data;
endmodule

// File: rtl/vperm_unit_chk.sv
module vperm_unit_chk
    import vperm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [OP_W-1:0]  op,
    input logic [VEC_W-1:0] src_a,
    input logic             out_valid,
    input logic             out_illegal,
    input logic [VEC_W-1:0] out_data
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_illegal && out_data == '0));

    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R10
    illegal_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op > OP_LAST_LEGAL) |=> (out_illegal && out_data == $past(src_a)));

    // R10
    legal_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op <= OP_LAST_LEGAL) |=> !out_illegal);

    // R10
    flag_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> out_valid);

    // R9
    b12_keeps_low_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 4'd9) |=> out_data[95:0] == $past(src_a[95:0]));

    // R9
    h0_keeps_high_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 4'd4) |=> out_data[127:64] == $past(src_a[127:64]));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !$past(rst)) |=> $stable(out_data));
endmodule

bind vperm_unit vperm_unit_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .op          (op),
    .src_a       (src_a),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_data    (out_data)
);

// File: tb/test_vperm_unit.sv
module test_vperm_unit;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [3:0]   op;
    logic [7:0]   imm;
    logic [127:0] src_a;
    logic [127:0] src_b;
    logic         out_valid;
    logic         out_illegal;
    logic [127:0] out_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    vperm_unit i_vperm_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .imm(imm),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
        .out_illegal(out_illegal), .out_data(out_data)
    );

    function automatic logic [127:0] ref_model(input logic [3:0] o, input logic [7:0] im,
                                               input logic [127:0] a, input logic [127:0] b);
        logic [127:0] r;
        int s, p, base;
        r = a;
        case (o)
            4'd0: for (int i = 0; i < 2; i++) begin
                s = int'(im[2*i +: 2]);
                r[64*i +: 64] = (s < 2) ? a[64*s +: 64] : b[64*(s-2) +: 64];
            end
            4'd1: for (int k = 0; k < 16; k++) begin
                p = int'(im[4:0]) + k;
                if (p < 16)      r[8*k +: 8] = b[8*p +: 8];
                else if (p < 32) r[8*k +: 8] = a[8*(p-16) +: 8];
                else             r[8*k +: 8] = 8'h00;
            end
            4'd2: for (int i = 0; i < 2; i++) begin
                s = int'(b[64*i]);
                r[64*i +: 64] = a[64*s +: 64];
            end
            4'd3: for (int i = 0; i < 4; i++) begin
                s = int'(b[32*i +: 2]);
                r[32*i +: 32] = a[32*s +: 32];
            end
            4'd4, 4'd5: begin
                base = (o == 4'd4) ? 0 : 4;
                for (int j = 0; j < 4; j++) begin
                    s = int'(im[2*j +: 2]);
                    r[16*(base+j) +: 16] = b[16*(base+s) +: 16];
                end
            end
            4'd6, 4'd7, 4'd8, 4'd9: begin
                base = 4 * (int'(o) - 6);
                for (int j = 0; j < 4; j++) begin
                    s = int'(im[2*j +: 2]);
                    r[8*(base+j) +: 8] = b[8*(base+s) +: 8];
                end
            end
            default: r = a;
        endcase
        return r;
    endfunction

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'd0: return "R3";
            4'd1: return "R4";
            4'd2: return "R5";
            4'd3: return "R6";
            4'd4, 4'd5: return "R7 R9";
            4'd6, 4'd7, 4'd8, 4'd9: return "R8 R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, sample 1 ns after the next rising edge.
    task automatic issue(input logic [3:0] o, input logic [7:0] im,
                         input logic [127:0] a, input logic [127:0] b);
        @(negedge clk);
        in_valid = 1'b1; op = o; imm = im; src_a = a; src_b = b;
        @(posedge clk);
        #1;
        check(req_of(o), out_data, ref_model(o, im, a, b));
        check("R2 valid", {127'd0, out_valid}, 128'd1);
        check("R10 flag", {127'd0, out_illegal}, {127'd0, (o > 4'd9)});
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    logic [127:0] va, vb, held;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; in_valid = 1'b0; op = '0; imm = '0; src_a = '0; src_b = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid", {127'd0, out_valid}, 128'd0);
        check("R1 flag", {127'd0, out_illegal}, 128'd0);
        check("R1 data", out_data, 128'd0);
        @(negedge clk);
        rst = 1'b0;

        for (int b = 0; b < 16; b++) va[8*b +: 8] = 8'h10 + 8'(b);
        for (int b = 0; b < 16; b++) vb[8*b +: 8] = 8'hA0 + 8'(b);

        // R4 window edges and masked high immediate bits
        issue(4'd1, 8'd0,  va, vb);
        issue(4'd1, 8'd15, va, vb);
        issue(4'd1, 8'd16, va, vb);
        issue(4'd1, 8'd31, va, vb);
        issue(4'd1, 8'hE5, va, vb);
        // R3 every selector value
        issue(4'd0, 8'b0000_1110, va, vb);
        issue(4'd0, 8'b0000_0100, va, vb);
        // R5 / R6 with high control bits set (must be ignored)
        issue(4'd2, 8'h00, va, {64'hFFFF_FFFF_FFFF_FFFE, 64'h0000_0000_0000_0001});
        issue(4'd3, 8'h00, va, {32'hFFFF_FFF0, 32'h8000_0001, 32'h7FFF_FFFE, 32'h0000_0003});
        // R7 R8 R9 each group, reversing selectors
        for (int o = 4; o < 10; o++) issue(4'(o), 8'b00_01_10_11, va, vb);
        // R10 all illegal codes
        for (int o = 10; o < 16; o++) issue(4'(o), 8'h5A, va, vb);

        // R11 idle hold: output unchanged while sources change
        issue(4'd1, 8'd7, va, vb);
        held = ref_model(4'd1, 8'd7, va, vb);
        @(negedge clk);
        in_valid = 1'b0; src_a = rnd128(); src_b = rnd128(); op = 4'd0;
        repeat (2) @(posedge clk);
        #1;
        check("R11 hold", out_data, held);
        check("R2 idle valid", {127'd0, out_valid}, 128'd0);

        // R2 back-to-back random stream
        for (int n = 0; n < 400; n++) begin
            issue(4'($urandom_range(0, 15)), 8'($urandom), rnd128(), rnd128());
        end

        @(negedge clk);
        in_valid = 1'b0;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule